// File: doc/BRIEF.md
# SD Card SPI-Mode Power-Up Sequencer

This block takes an SD card from power-on into the initialized SPI-mode state. It drives a byte-wide SPI shifter through a simple request/acknowledge port, so it never toggles the serial clock itself. It sets the divider output that paces that shifter. While it runs, it keeps the divider at the slow rate suited to card identification.

A start pulse begins the sequence. The block first waits a prescaled power-up delay. It then clocks out a preamble of all-ones bytes with chip select released. Next it sends the go-idle command (CMD0) and polls for the idle response. After that it repeats the leave-idle command (CMD1) until the card reports ready or a prescaled timeout runs out. The outcome is a two-bit code. Only on success is the divider switched to the fast value.

Top module: `sdInitSeq`

## Requirements
- R1: After reset, busy, xferReq and csActive are 0, resultCode is 00 and spiDivider equals SLOW_DIV.
- R2: A startReq seen while idle makes busy 1 on the next cycle and loads SLOW_DIV into spiDivider. A startReq seen while busy has no effect on the byte stream or the outcome.
- R3: xferReq first rises exactly (DLY_TERM+1)*DLY_STEP+1 cycles after busy rises. No request is made before that.
- R4: The preamble is PRE_LEN bytes of 0xFF, each sent with csActive at 0.
- R5: The go-idle frame is the bytes 0x40, 0x00, 0x00, 0x00, 0x00, 0x95, sent with csActive at 1. It is followed by poll bytes of 0xFF, also with csActive at 1.
- R6: Only a received byte equal to 0x01 during one of the first POLL_LIMIT poll bytes after the go-idle frame accepts that step. Any other value, including 0x00, does not. If no poll byte matches, the run ends with resultCode 01 and spiDivider stays SLOW_DIV.
- R7: The leave-idle frame is the bytes 0x41, 0x00, 0x00, 0x00, 0x00, 0xFF with csActive at 1, followed by up to POLL_LIMIT poll bytes of 0xFF. A received 0x00 ends the run with resultCode 00 and spiDivider equal to FAST_DIV.
- R8: A leave-idle attempt whose POLL_LIMIT polls bring no 0x00 is repeated, unless the timeout has expired. The timeout has expired when at least (TOUT_TERM+1)*TOUT_STEP cycles have passed since the cycle after the go-idle step was accepted. The check is made at the last poll of the attempt. An expired timeout ends the run with resultCode 10.
- R9: A byte moves on each cycle in which xferReq and xferAck are both 1, and xferRxByte is taken in that cycle. While xferReq is 1 and xferAck is 0, xferReq and xferTxByte hold. xferReq is 0 whenever busy is 0.
- R10: busy falls in the cycle after the final acknowledge. While idle, resultCode and spiDivider keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Start pulse, 1 = begin the sequence |
| busy | output | 1 | 1 while the sequence runs, 0 when idle |
| resultCode | output | 2 | 00 success, 01 go-idle step failed, 10 leave-idle step timed out |
| spiDivider | output | DIV_W | Clock divider value for the SPI shifter |
| csActive | output | 1 | 1 = chip select asserted |
| xferReq | output | 1 | Byte transfer request to the shifter |
| xferTxByte | output | 8 | Byte to send |
| xferAck | input | 1 | Shifter finished a byte this cycle |
| xferRxByte | input | 8 | Byte received, valid with xferAck |

## Verification
The sequence is run against card responders that differ in where and what they answer. One answers the go-idle poll on a middle byte and the leave-idle poll on a later attempt. One never answers. One answers 0x00 before the idle code, then never becomes ready. One answers on the very first and very last poll positions. Together these separate early acceptance, wrong-value acceptance, off-by-one poll limits and a timeout compared against the wrong cycle. Acknowledge latency varies per byte to expose any request that does not hold. A start pulse injected during a run shows whether the sequence restarts.

// File: rtl/sdInitPkg.sv
package sdInitPkg;

  localparam int CMD_LEN = 6;

  localparam logic [1:0] RES_OK   = 2'b00;
  localparam logic [1:0] RES_CMD0 = 2'b01;
  localparam logic [1:0] RES_CMD1 = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_CMD,
    ST_POLL
  } seqStateT;

  typedef struct packed {
    logic       clrCnt;
    logic       incCnt;
    logic       clrDelay;
    logic       clrTout;
    logic       setSlow;
    logic       setFast;
    logic       loadRes;
    logic [1:0] resVal;
    logic       txCmd;
    logic       isCmd1;
  } ctlStrobeT;

endpackage

// File: rtl/sdInitTimer.sv
module sdInitTimer #(
  parameter int STEP = 256,
  parameter int TERM = 375
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);

  localparam int PW = (STEP > 1) ? $clog2(STEP) : 1;
  localparam int TW = $clog2(TERM + 2);

  logic [PW-1:0] preCnt;
  logic [TW-1:0] termCnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      preCnt  <= '0;
      termCnt <= '0;
      done    <= 1'b0;
    end else if (!done) begin
      if (preCnt == PW'(STEP - 1)) begin
        preCnt <= '0;
        if (termCnt == TW'(TERM)) done <= 1'b1;
        else termCnt <= termCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R8: once expired, the flag holds until the next clear
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done && !clr |=> done);

endmodule

// File: rtl/sdInitDp.sv
module sdInitDp
  import sdInitPkg::*;
#(
  parameter int             DIV_W     = 8,
  parameter logic [DIV_W-1:0] SLOW_DIV = 8'h3B,
  parameter logic [DIV_W-1:0] FAST_DIV = 8'h00,
  parameter int             CNT_W     = 8,
  parameter int             DLY_STEP  = 256,
  parameter int             DLY_TERM  = 375,
  parameter int             TOUT_STEP = 65536,
  parameter int             TOUT_TERM = 182
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobeT        stb,
  output logic [CNT_W-1:0] byteCnt,
  output logic             delayDone,
  output logic             toutDone,
  output logic [7:0]       txByte,
  output logic [DIV_W-1:0] spiDivider,
  output logic [1:0]       resultCode
);

  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt    <= '0;
      spiDivider <= SLOW_DIV;
      resultCode <= RES_OK;
    end else begin
      if (stb.clrCnt)      byteCnt <= '0;
      else if (stb.incCnt) byteCnt <= byteCnt + 1'b1;
      if (stb.setSlow)      spiDivider <= SLOW_DIV;
      else if (stb.setFast) spiDivider <= FAST_DIV;
      if (stb.loadRes) resultCode <= stb.resVal;
    end
  end

  always_comb begin
    txByte = 8'hFF;
    if (stb.txCmd) begin
      if (byteCnt == '0)                       txByte = stb.isCmd1 ? 8'h41 : 8'h40;
      else if (byteCnt == CNT_W'(CMD_LEN - 1)) txByte = stb.isCmd1 ? 8'hFF : 8'h95;
      else                                     txByte = 8'h00;
    end
  end

  sdInitTimer #(.STEP(DLY_STEP), .TERM(DLY_TERM)) uDelay (
    .clk(clk), .rst(rst), .clr(stb.clrDelay), .done(delayDone)
  );

  sdInitTimer #(.STEP(TOUT_STEP), .TERM(TOUT_TERM)) uTout (
    .clk(clk), .rst(rst), .clr(stb.clrTout), .done(toutDone)
  );

endmodule

// File: rtl/sdInitCtrl.sv
module sdInitCtrl
  import sdInitPkg::*;
#(
  parameter int PRE_LEN    = 160,
  parameter int POLL_LIMIT = 8,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             xferAck,
  input  logic [7:0]       xferRxByte,
  input  logic [CNT_W-1:0] byteCnt,
  input  logic             delayDone,
  input  logic             toutDone,
  output ctlStrobeT        stb,
  output logic             busy,
  output logic             xferReq,
  output logic             csActive
);

  seqStateT state, nxtState;
  logic     isCmd1, nxtCmd1;
  logic     hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      isCmd1 <= 1'b0;
    end else begin
      state  <= nxtState;
      isCmd1 <= nxtCmd1;
    end
  end

  assign hit = isCmd1 ? (xferRxByte == 8'h00) : (xferRxByte == 8'h01);

  always_comb begin
    stb        = '0;
    nxtState   = state;
    nxtCmd1    = isCmd1;
    stb.txCmd  = (state == ST_CMD);
    stb.isCmd1 = isCmd1;
    unique case (state)
      ST_IDLE: if (startReq) begin
        stb.setSlow  = 1'b1;
        stb.clrDelay = 1'b1;
        nxtCmd1      = 1'b0;
        nxtState     = ST_WAIT;
      end
      ST_WAIT: if (delayDone) begin
        stb.clrCnt = 1'b1;
        nxtState   = ST_PRE;
      end
      ST_PRE: if (xferAck) begin
        if (byteCnt == CNT_W'(PRE_LEN - 1)) begin
          stb.clrCnt = 1'b1;
          nxtState   = ST_CMD;
        end else stb.incCnt = 1'b1;
      end
      ST_CMD: if (xferAck) begin
        if (byteCnt == CNT_W'(CMD_LEN - 1)) begin
          stb.clrCnt = 1'b1;
          nxtState   = ST_POLL;
        end else stb.incCnt = 1'b1;
      end
      ST_POLL: if (xferAck) begin
        if (hit && !isCmd1) begin
          stb.clrCnt  = 1'b1;
          stb.clrTout = 1'b1;
          nxtCmd1     = 1'b1;
          nxtState    = ST_CMD;
        end else if (hit) begin
          stb.loadRes = 1'b1;
          stb.resVal  = RES_OK;
          stb.setFast = 1'b1;
          nxtState    = ST_IDLE;
        end else if (byteCnt == CNT_W'(POLL_LIMIT - 1)) begin
          if (!isCmd1 || toutDone) begin
            stb.loadRes = 1'b1;
            stb.resVal  = isCmd1 ? RES_CMD1 : RES_CMD0;
            nxtState    = ST_IDLE;
          end else begin
            stb.clrCnt = 1'b1;
            nxtState   = ST_CMD;
          end
        end else stb.incCnt = 1'b1;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign xferReq  = (state == ST_PRE) || (state == ST_CMD) || (state == ST_POLL);
  assign csActive = (state == ST_CMD) || (state == ST_POLL);

  // R6: an idle-code answer to go-idle always leads into the leave-idle frame
  a_r6_cmd0_accept: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL) && xferAck && !isCmd1 && (xferRxByte == 8'h01)
    |=> (state == ST_CMD) && isCmd1 && (byteCnt == '0));

  // R2: a start during a run does not reopen the power-up wait
  a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy && startReq && (state != ST_WAIT) |=> (state != ST_WAIT));

endmodule

// File: rtl/sdInitSeq.sv
module sdInitSeq
  import sdInitPkg::*;
#(
  parameter int               DIV_W      = 8,
  parameter logic [DIV_W-1:0] SLOW_DIV   = 8'h3B,
  parameter logic [DIV_W-1:0] FAST_DIV   = 8'h00,
  parameter int               PRE_LEN    = 160,
  parameter int               POLL_LIMIT = 8,
  parameter int               DLY_STEP   = 256,
  parameter int               DLY_TERM   = 375,
  parameter int               TOUT_STEP  = 65536,
  parameter int               TOUT_TERM  = 182
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  output logic             busy,
  output logic [1:0]       resultCode,
  output logic [DIV_W-1:0] spiDivider,
  output logic             csActive,
  output logic             xferReq,
  output logic [7:0]       xferTxByte,
  input  logic             xferAck,
  input  logic [7:0]       xferRxByte
);

  localparam int CNT_MAX0 = (PRE_LEN > POLL_LIMIT) ? PRE_LEN : POLL_LIMIT;
  localparam int CNT_MAX  = (CNT_MAX0 > CMD_LEN) ? CNT_MAX0 : CMD_LEN;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  ctlStrobeT        stb;
  logic [CNT_W-1:0] byteCnt;
  logic             delayDone;
  logic             toutDone;

  sdInitCtrl #(.PRE_LEN(PRE_LEN), .POLL_LIMIT(POLL_LIMIT), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst(rst), .startReq(startReq), .xferAck(xferAck),
    .xferRxByte(xferRxByte), .byteCnt(byteCnt), .delayDone(delayDone),
    .toutDone(toutDone), .stb(stb), .busy(busy), .xferReq(xferReq),
    .csActive(csActive)
  );

  sdInitDp #(
    .DIV_W(DIV_W), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV), .CNT_W(CNT_W),
    .DLY_STEP(DLY_STEP), .DLY_TERM(DLY_TERM),
    .TOUT_STEP(TOUT_STEP), .TOUT_TERM(TOUT_TERM)
  ) uDp (
    .clk(clk), .rst(rst), .stb(stb), .byteCnt(byteCnt), .delayDone(delayDone),
    .toutDone(toutDone), .txByte(xferTxByte), .spiDivider(spiDivider),
    .resultCode(resultCode)
  );

  // R1: the slow divider is in force for the whole run
  a_r1_slow_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (spiDivider == SLOW_DIV));

  // R7: the fast divider appears exactly when a run ends in success
  a_r7_fast_on_success: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ((resultCode == RES_OK) == (spiDivider == FAST_DIV)));

  // R9: an unacknowledged request holds with the same byte
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    xferReq && !xferAck |=> xferReq && $stable(xferTxByte));

  // R9: no request while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !xferReq);

  // R5: every byte other than 0xFF goes out with chip select asserted
  a_r5_cmd_under_cs: assert property (@(posedge clk) disable iff (rst)
    xferReq && (xferTxByte != 8'hFF) |-> csActive);

  // R10: the outcome holds while idle
  a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(busy) |-> $stable(resultCode) && $stable(spiDivider));

endmodule

// File: tb/sim_sdInitSeq.sv
`timescale 1ns/1ps
module sim_sdInitSeq;

  localparam int         DIV_W      = 8;
  localparam logic [7:0] SLOW_DIV   = 8'h3B;
  localparam logic [7:0] FAST_DIV   = 8'h00;
  localparam int         PRE_LEN    = 5;
  localparam int         POLL_LIMIT = 8;
  localparam int         DLY_STEP   = 4;
  localparam int         DLY_TERM   = 2;
  localparam int         TOUT_STEP  = 8;
  localparam int         TOUT_TERM  = 9;
  localparam int         DLY_WIN    = (DLY_TERM + 1) * DLY_STEP;
  localparam int         TOUT_WIN   = (TOUT_TERM + 1) * TOUT_STEP;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startReq = 1'b0;
  logic       xferAck = 1'b0;
  logic [7:0] xferRxByte = 8'hFF;
  logic       busy, csActive, xferReq;
  logic [1:0] resultCode;
  logic [7:0] spiDivider, xferTxByte;

  sdInitSeq #(
    .DIV_W(DIV_W), .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV), .PRE_LEN(PRE_LEN),
    .POLL_LIMIT(POLL_LIMIT), .DLY_STEP(DLY_STEP), .DLY_TERM(DLY_TERM),
    .TOUT_STEP(TOUT_STEP), .TOUT_TERM(TOUT_TERM)
  ) u0 (
    .clk(clk), .rst(rst), .startReq(startReq), .busy(busy),
    .resultCode(resultCode), .spiDivider(spiDivider), .csActive(csActive),
    .xferReq(xferReq), .xferTxByte(xferTxByte), .xferAck(xferAck),
    .xferRxByte(xferRxByte)
  );

  always #2.5 clk = ~clk;

  int   cyc = 0;
  int   nCmp = 0;
  int   nBad = 0;
  int   gapCnt = 0;
  int   lastAckEdge = 0;
  int   cmd1Start = 0;
  bit   cmpOn = 1'b0;
  bit   finished = 1'b0;
  logic       expBusy = 1'b0;
  logic [7:0] expDiv = SLOW_DIV;
  logic [1:0] expRes = 2'b00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", tag, cyc, act, exp);
    end
  endtask

  // per-clock comparison against the reference state
  always @(negedge clk) if (cmpOn) begin
    chk(busy === expBusy, "R2/R10 busy", busy, expBusy);
    chk(spiDivider === expDiv, "R1/R7 divider", spiDivider, expDiv);
    if (!expBusy) begin
      chk(xferReq === 1'b0, "R9 idle request", xferReq, 0);
      chk(resultCode === expRes, "R10 result", resultCode, expRes);
    end
  end

  function automatic logic [7:0] frameByte(input bit c1, input int i);
    if (i == 0) return c1 ? 8'h41 : 8'h40;
    if (i == 5) return c1 ? 8'hFF : 8'h95;
    return 8'h00;
  endfunction

  // endMode: -1 none, 0..2 the run ends with that code, 3 ends with code 2 if timed out
  task automatic xfer(input logic [7:0] expTx, input logic expCs, input logic [7:0] rx,
                      input string tag, input int endMode, output bit ended);
    int w = 0;
    ended = 1'b0;
    while (xferReq !== 1'b1 && w < 3000) begin @(negedge clk); w++; end
    chk(xferReq === 1'b1, {tag, " request"}, xferReq, 1);
    chk(xferTxByte === expTx, {tag, " tx byte"}, xferTxByte, expTx);
    chk(csActive === expCs, {tag, " chip select"}, csActive, expCs);
    repeat (gapCnt % 3) begin
      @(negedge clk);
      chk(xferReq === 1'b1 && xferTxByte === expTx, "R9 hold", xferTxByte, expTx);
    end
    gapCnt++;
    lastAckEdge = cyc + 1;
    xferAck = 1'b1;
    xferRxByte = rx;
    @(posedge clk);
    if (endMode == 3) ended = (lastAckEdge - cmd1Start - 1) >= TOUT_WIN;
    else if (endMode >= 0) ended = 1'b1;
    if (ended) begin
      expBusy = 1'b0;
      expRes = (endMode == 3) ? 2'b10 : 2'(endMode);
      expDiv = (expRes == 2'b00) ? FAST_DIV : SLOW_DIV;
    end
    @(negedge clk);
    xferAck = 1'b0;
    xferRxByte = 8'hFF;
  endtask

  task automatic runSeq(input int c0Junk, input int c0Hit, input int c1HitA,
                        input int c1HitP, input bit poke, input logic [1:0] wantRes);
    int n = 0;
    int attempts = 0;
    bit ended = 1'b0;
    bit hit;
    logic [7:0] rx;
    startReq = 1'b1;
    @(posedge clk);
    expBusy = 1'b1;
    expDiv = SLOW_DIV;
    @(negedge clk);
    startReq = 1'b0;
    while (xferReq !== 1'b1 && n < 5000) begin n++; @(negedge clk); end
    chk(n == DLY_WIN + 1, "R3 delay cycles", n, DLY_WIN + 1);
    for (int i = 0; i < PRE_LEN; i++) begin
      startReq = poke;  // R2: start while busy
      xfer(8'hFF, 1'b0, 8'hFF, "R4 preamble", -1, ended);
      startReq = 1'b0;
    end
    for (int i = 0; i < 6; i++) xfer(frameByte(1'b0, i), 1'b1, 8'hFF, "R5 go-idle frame", -1, ended);
    hit = 1'b0;
    for (int p = 0; p < POLL_LIMIT && !hit; p++) begin
      rx = (p == c0Hit) ? 8'h01 : ((p == c0Junk) ? 8'h00 : 8'hFF);
      hit = (rx == 8'h01);
      xfer(8'hFF, 1'b1, rx, "R6 go-idle poll", (!hit && p == POLL_LIMIT - 1) ? 1 : -1, ended);
      if (hit) cmd1Start = lastAckEdge;
    end
    while (!ended && attempts < 100) begin
      attempts++;
      for (int i = 0; i < 6; i++) xfer(frameByte(1'b1, i), 1'b1, 8'hFF, "R7 leave-idle frame", -1, ended);
      for (int p = 0; p < POLL_LIMIT && !ended; p++) begin
        hit = (attempts - 1 == c1HitA) && (p == c1HitP);
        xfer(8'hFF, 1'b1, hit ? 8'h00 : 8'h01, "R8 leave-idle poll",
             hit ? 0 : ((p == POLL_LIMIT - 1) ? 3 : -1), ended);
      end
    end
    chk(resultCode === wantRes, "R6/R7/R8 outcome", resultCode, wantRes);
    if (wantRes == 2'b10) chk(attempts >= 2, "R8 retried", attempts, 2);
    repeat (10) @(negedge clk);  // R10: idle hold observed by the per-clock check
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(xferReq === 1'b0, "R1 request", xferReq, 0);
    chk(csActive === 1'b0, "R1 chip select", csActive, 0);
    chk(resultCode === 2'b00, "R1 result", resultCode, 0);
    chk(spiDivider === SLOW_DIV, "R1 divider", spiDivider, SLOW_DIV);
    rst = 1'b0;
    cmpOn = 1'b1;
    repeat (4) @(negedge clk);
    runSeq(-1, 2, 1, 1, 1'b1, 2'b00);   // R7 success on second attempt, R2 poke
    runSeq(-1, -1, -1, -1, 1'b0, 2'b01); // R6 silent card
    runSeq(0, 4, -1, -1, 1'b0, 2'b10);   // R6 wrong code first, R8 timeout
    runSeq(-1, 0, 0, 7, 1'b0, 2'b00);    // first and last poll positions
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule